// File: doc/BRIEF.md
# Trace Memory Step Sequencer

This block walks an address pointer across a programmable window of trace memory, one entry per qualified edge on an external advance line. Software programs the window bounds on two address inputs. A control register enables the trace, chooses what happens at the top of the window, and records which of the plug-in modules take part in trace mode. A small polarity register picks the active slope of the advance input, of the advance output and of a board-busy trigger.

Each accepted advance edge does two things. It moves the pointer to the next entry, and it emits a one-cycle pulse on the advance output whose leading edge has the programmed slope. When the pointer reaches the window's last address and one more edge arrives, the block does one of two things. With looping on, it returns to the first address and the enable stays set. With looping off, the pointer stays where it is and the enable bit is cleared in hardware. Software sees that clear when it reads the register back.

Top module: `trace_step_seq`

## Requirements
- R1: After hard reset `ptr` is 0, `ctl_rdata` is 0, `mod_mask` is 0, `busy_rise_sel` is 0 and `adv_out` is 1 (the idle level for a falling-edge output).
- R2: `ctl_rdata` returns trace enable in bit 0, loop enable in bit 1, the written bits 3:2 in bits 3:2 and the module mask in bits 9:4. Bits 15:10 read 0.
- R3: A control write that sets bit 0 while the trace enable is 0 loads `start_addr` into `ptr` on that clock edge.
- R4: While the trace enable is 0, advance edges leave `ptr` unchanged and produce no output pulse.
- R5: Polarity bit 1 selects the advance input slope: 1 means rising, 0 means falling. The opposite slope is ignored. A level change on `adv_in` moves `ptr` on the third rising clock edge after the change.
- R6: Each accepted edge below the window end adds exactly 1 to `ptr`. A held level produces no further steps.
- R7: With loop enable 1, an edge accepted at `ptr == end_addr` loads `start_addr`, and the trace enable stays 1.
- R8: With loop enable 0, an edge accepted at `ptr == end_addr` keeps `ptr` and clears the trace enable. Bit 0 of `ctl_rdata` then reads 0.
- R9: Polarity bit 0 selects the output slope. Each step drives `adv_out` to that bit's value for exactly one cycle, in the cycle where `ptr` changes. Otherwise `adv_out` rests at the inverse value.
- R10: `soft_rst` clears polarity bits 3:0 and keeps bit 4 (`busy_rise_sel`). Hard `rst` clears all polarity and control state.
- R11: `mod_mask[k]` is control bit 4+k, so module 0 is bit 4 and module 5 is bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| soft_rst | input | 1 | Synchronous soft reset of polarity bits 3:0 |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 4+NUM_MOD | Control write data |
| ctl_rdata | output | 16 | Control register read-back |
| pol_we | input | 1 | Polarity register write strobe |
| pol_wdata | input | 5 | Polarity write data |
| start_addr | input | ADDR_W | First address of the active window |
| end_addr | input | ADDR_W | Last address of the active window |
| adv_in | input | 1 | Asynchronous advance input |
| ptr | output | ADDR_W | Current trace address |
| adv_out | output | 1 | Advance output pulse |
| mod_mask | output | NUM_MOD | Modules taking part in trace mode |
| busy_rise_sel | output | 1 | Board-busy slope select (1 = rising) |

## Verification
A level change on `adv_in` reaches `ptr` and `adv_out` together on the third clock edge: two edges for the synchronizer, one for the step register. The output pulse ends on the fourth edge. Control and polarity writes take effect on the edge that samples the strobe. The bench drives every input on a falling clock edge and then counts whole cycles: three after an input change before it reads the stepped pointer and the pulse, one more for the idle level, and one after each write. All reads happen at falling edges, away from the edge that updates the state.

// File: rtl/trace_seq_pkg.sv
package trace_seq_pkg;
  localparam int CTL_RD_W    = 16;
  localparam int CTL_EN      = 0;
  localparam int CTL_LOOP    = 1;
  localparam int CTL_SPARE   = 2;
  localparam int CTL_MASK_LO = 4;
  localparam int POL_W       = 5;
  localparam int POL_OUT     = 0;
  localparam int POL_IN      = 1;
  localparam int POL_BUSY    = 4;
endpackage

// File: rtl/tss_edge_detect.sv
module tss_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic rise_sel,
  output logic hit
);
  // sh[SYNC_STAGES-1] is the synchronized level, sh[SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC_STAGES-1:0], din};
  end

  always_comb begin
    if (rise_sel) hit = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
    else          hit = ~sh[SYNC_STAGES-1] & sh[SYNC_STAGES];
  end
endmodule

// File: rtl/tss_regs.sv
module tss_regs
  import trace_seq_pkg::*;
#(
  parameter int NUM_MOD = 6,
  localparam int CW = CTL_MASK_LO + NUM_MOD
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                soft_rst,
  input  logic                ctl_we,
  input  logic [CW-1:0]       ctl_wdata,
  input  logic                pol_we,
  input  logic [POL_W-1:0]    pol_wdata,
  input  logic                hw_clr,
  output logic [CTL_RD_W-1:0] ctl_rdata,
  output logic                trace_en,
  output logic                loop_en,
  output logic                load_start,
  output logic [NUM_MOD-1:0]  mod_mask,
  output logic [POL_W-1:0]    pol
);
  logic [1:0] spare;

  assign load_start = ctl_we & ctl_wdata[CTL_EN] & ~trace_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      trace_en <= 1'b0;
      loop_en  <= 1'b0;
      spare    <= '0;
      mod_mask <= '0;
    end else if (ctl_we) begin
      trace_en <= ctl_wdata[CTL_EN];
      loop_en  <= ctl_wdata[CTL_LOOP];
      spare    <= ctl_wdata[CTL_SPARE +: 2];
      mod_mask <= ctl_wdata[CTL_MASK_LO +: NUM_MOD];
    end else if (hw_clr) begin
      trace_en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pol <= '0;
    end else if (pol_we) begin
      pol <= pol_wdata;
    end else if (soft_rst) begin
      pol[3:0] <= '0;
    end
  end

  always_comb begin
    ctl_rdata = '0;
    ctl_rdata[CTL_EN]   = trace_en;
    ctl_rdata[CTL_LOOP] = loop_en;
    ctl_rdata[CTL_SPARE +: 2] = spare;
    ctl_rdata[CTL_MASK_LO +: NUM_MOD] = mod_mask;
  end
endmodule

// File: rtl/tss_pointer.sv
module tss_pointer #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              load,
  input  logic              loop_en,
  input  logic              out_rise,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  output logic [ADDR_W-1:0] ptr,
  output logic              adv_out,
  output logic              hw_clr
);
  logic at_end;

  assign at_end = (ptr == end_addr);
  assign hw_clr = step & at_end & ~loop_en & ~load;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= start_addr;
    end else if (step) begin
      if (!at_end)     ptr <= ptr + 1'b1;
      else if (loop_en) ptr <= start_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) adv_out <= 1'b1;
    else     adv_out <= step ? out_rise : ~out_rise;
  end
endmodule

// File: rtl/trace_step_seq.sv
module trace_step_seq
  import trace_seq_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int NUM_MOD     = 6,
  parameter int SYNC_STAGES = 2,
  localparam int CW = CTL_MASK_LO + NUM_MOD
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                soft_rst,
  input  logic                ctl_we,
  input  logic [CW-1:0]       ctl_wdata,
  output logic [CTL_RD_W-1:0] ctl_rdata,
  input  logic                pol_we,
  input  logic [POL_W-1:0]    pol_wdata,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic [ADDR_W-1:0]   end_addr,
  input  logic                adv_in,
  output logic [ADDR_W-1:0]   ptr,
  output logic                adv_out,
  output logic [NUM_MOD-1:0]  mod_mask,
  output logic                busy_rise_sel
);
  logic             trace_en, loop_en, load_start, hw_clr, hit, step, out_rise;
  logic [POL_W-1:0] pol;

  assign out_rise      = pol[POL_OUT];
  assign busy_rise_sel = pol[POL_BUSY];
  assign step          = hit & trace_en;

  tss_regs #(.NUM_MOD(NUM_MOD)) u_regs (
    .clk(clk), .rst(rst), .soft_rst(soft_rst),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .pol_we(pol_we), .pol_wdata(pol_wdata),
    .hw_clr(hw_clr), .ctl_rdata(ctl_rdata),
    .trace_en(trace_en), .loop_en(loop_en), .load_start(load_start),
    .mod_mask(mod_mask), .pol(pol)
  );

  tss_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .din(adv_in),
    .rise_sel(pol[POL_IN]), .hit(hit)
  );

  tss_pointer #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .step(step), .load(load_start),
    .loop_en(loop_en), .out_rise(out_rise),
    .start_addr(start_addr), .end_addr(end_addr),
    .ptr(ptr), .adv_out(adv_out), .hw_clr(hw_clr)
  );
endmodule

// File: rtl/tss_checker.sv
module tss_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ctl_we,
  input logic              step,
  input logic              load,
  input logic              en,
  input logic              loop_en,
  input logic              out_rise,
  input logic [ADDR_W-1:0] start_addr,
  input logic [ADDR_W-1:0] end_addr,
  input logic [ADDR_W-1:0] ptr,
  input logic              adv_out
);
  assert_load_start_R3: assert property (@(posedge clk) disable iff (rst)
    load |=> ptr == $past(start_addr));

  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(ptr));

  assert_increment_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !load && ptr != end_addr) |=> ptr == ADDR_W'($past(ptr) + 1'b1));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !ctl_we && loop_en && ptr == end_addr)
      |=> (ptr == $past(start_addr) && en));

  assert_stop_R8: assert property (@(posedge clk) disable iff (rst)
    (step && !ctl_we && !loop_en && ptr == end_addr) |=> (!en && $stable(ptr)));

  assert_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    step |=> adv_out == $past(out_rise));

  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !step |=> adv_out != $past(out_rise));
endmodule

bind trace_step_seq tss_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .ctl_we(ctl_we), .step(step), .load(load_start),
  .en(trace_en), .loop_en(loop_en), .out_rise(out_rise),
  .start_addr(start_addr), .end_addr(end_addr), .ptr(ptr), .adv_out(adv_out)
);

// File: tb/trace_step_seq_tb.sv
module trace_step_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NM = 6;
  localparam int CW = 4 + NM;
  // {adv_in level, expected ptr} with window 4..7, loop on, rising input
  localparam logic [8:0] VEC [0:7] = '{9'h105, 9'h005, 9'h106, 9'h006,
                                       9'h107, 9'h007, 9'h104, 9'h004};

  logic          clk = 0, rst = 1, soft_rst = 0, ctl_we = 0, pol_we = 0, adv_in = 0;
  logic [CW-1:0] ctl_wdata = '0;
  logic [4:0]    pol_wdata = '0;
  logic [AW-1:0] start_addr = '0, end_addr = '0, ptr;
  logic [15:0]   ctl_rdata;
  logic          adv_out, busy_rise_sel;
  logic [NM-1:0] mod_mask;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_step_seq u_dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .pol_we(pol_we),
    .pol_wdata(pol_wdata), .start_addr(start_addr), .end_addr(end_addr),
    .adv_in(adv_in), .ptr(ptr), .adv_out(adv_out), .mod_mask(mod_mask),
    .busy_rise_sel(busy_rise_sel)
  );

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(logic [CW-1:0] d);
    ctl_wdata = d; ctl_we = 1; cyc(1); ctl_we = 0;
  endtask

  task automatic wr_pol(logic [4:0] d);
    pol_wdata = d; pol_we = 1; cyc(1); pol_we = 0;
  endtask

  task automatic drive_adv(logic v);
    adv_in = v; cyc(4);
  endtask

  initial begin
    cyc(3); rst = 0; cyc(1);
    check("R1 ptr", 16'(ptr), 16'h0);
    check("R1 rdata", ctl_rdata, 16'h0);
    check("R1 adv_out", 16'(adv_out), 16'h1);
    check("R1 busy", 16'(busy_rise_sel), 16'h0);

    wr_ctl(10'h3FE);
    check("R2 readback all", ctl_rdata, 16'h03FE);
    check("R11 mask all", 16'(mod_mask), 16'h3F);
    wr_ctl(10'h014);
    check("R2 readback", ctl_rdata, 16'h0014);
    check("R11 module0 is bit4", 16'(mod_mask), 16'h01);

    wr_pol(5'h12);                  // input rising, output falling, busy rising
    drive_adv(1); drive_adv(0);
    check("R4 disabled ptr", 16'(ptr), 16'h0);
    check("R4 no pulse", 16'(adv_out), 16'h1);

    start_addr = 8'd4; end_addr = 8'd7;
    wr_ctl(10'h003);
    check("R3 load start", 16'(ptr), 16'h4);

    for (int i = 0; i < 8; i++) begin
      drive_adv(VEC[i][8]);
      check($sformatf("R6 R7 vec%0d", i), 16'(ptr), 16'(VEC[i][7:0]));
    end
    check("R7 enable kept", ctl_rdata, 16'h0003);

    // output falling: pulse low for one cycle
    adv_in = 1; cyc(3);
    check("R9 pulse low", 16'(adv_out), 16'h0);
    check("R5 ptr on third edge", 16'(ptr), 16'h5);
    cyc(1);
    check("R9 idle high", 16'(adv_out), 16'h1);
    drive_adv(0);
    check("R6 held level no step", 16'(ptr), 16'h5);

    wr_pol(5'h13); cyc(1);          // output rising
    check("R9 idle low", 16'(adv_out), 16'h0);
    adv_in = 1; cyc(3);
    check("R9 pulse high", 16'(adv_out), 16'h1);
    cyc(1);
    check("R9 back low", 16'(adv_out), 16'h0);
    drive_adv(0);

    wr_pol(5'h11);                  // input falling
    drive_adv(1);
    check("R5 rising ignored", 16'(ptr), 16'h6);
    drive_adv(0);
    check("R5 falling steps", 16'(ptr), 16'h7);

    wr_ctl(10'h001);                // loop off
    drive_adv(1); drive_adv(0);
    check("R8 ptr holds end", 16'(ptr), 16'h7);
    check("R8 enable cleared", ctl_rdata, 16'h0000);
    drive_adv(1); drive_adv(0);
    check("R4 after stop", 16'(ptr), 16'h7);

    soft_rst = 1; cyc(1); soft_rst = 0; cyc(1);
    check("R10 busy kept", 16'(busy_rise_sel), 16'h1);
    check("R10 out slope cleared", 16'(adv_out), 16'h1);
    wr_ctl(10'h3F3); wr_pol(5'h1F);
    rst = 1; cyc(1); rst = 0; cyc(1);
    check("R10 hard busy", 16'(busy_rise_sel), 16'h0);
    check("R10 hard ctl", ctl_rdata, 16'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule